// File: doc/BRIEF.md
# Serial Access Buffer Port

This block is the serial side of a dual-port video memory: a static buffer of 512 four-bit entries with a 9-bit address pointer, clocked by a system clock. Each serial clock rising edge reaches the block as a one-cycle `step_i` pulse. A transfer strobe loads a start address into the pointer and latches a 2-bit transfer code. That code sets the direction of the serial port until the next transfer.

In write mode, each step captures the serial input nibble into the entry under the pointer, unless the mask input is high. In read mode the entry under the pointer is presented on the serial output, with an output-enable flag. The pointer moves forward on every step in both modes and whether or not the mask is set. This lets the mask act as a write mask for single locations. The buffer is static and needs no refresh. A side read port exposes any entry so that stored contents can be inspected.

Top module: `sam_port`

## Requirements
- R1: After reset the port is in read mode, the pointer is 0 and every entry holds 0.
- R2: A transfer strobe with code 2'b00 (read) selects read mode. Code 2'b01 (write) or 2'b10 (pseudo) selects write mode. The new mode applies from the next cycle.
- R3: A transfer strobe with code 00, 01 or 10 loads the pointer with `xfer_addr_i`.
- R4: A transfer strobe with code 2'b11 is ignored: mode and pointer keep their values.
- R5: In write mode, a step with `mask_i` low writes `sdata_i` into the entry at the pointer.
- R6: In write mode, a step with `mask_i` high leaves the buffer unchanged.
- R7: Every step advances the pointer by one, in either mode and whatever the mask.
- R8: A step at pointer 511 moves the pointer to 0.
- R9: `sdata_oe_o` is 1 only in read mode with `mask_i` low. When it is 1, `sdata_o` equals the entry at the pointer; otherwise `sdata_o` is 0.
- R10: A step in the same cycle as a transfer strobe is ignored: it neither writes nor advances the pointer.
- R11: `peek_data_o` shows the entry at `peek_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_strobe_i | input | 1 | Transfer cycle strobe |
| xfer_kind_i | input | 2 | Transfer code: 00 read, 01 write, 10 pseudo, 11 reserved |
| xfer_addr_i | input | 9 | Start address for the pointer |
| step_i | input | 1 | One serial clock rising edge |
| mask_i | input | 1 | High: suppress write and disable output |
| sdata_i | input | 4 | Serial write data |
| sdata_o | output | 4 | Serial read data |
| sdata_oe_o | output | 1 | Serial output enable (low stands for high impedance) |
| peek_addr_i | input | 9 | Side read address |
| peek_data_o | output | 4 | Side read data |

## Verification
The hardest case is a masked location. It sits between written neighbours, and the wrap from 511 to 0 falls inside the same burst, so a pointer that stalls on a masked step shows up as shifted data. The stimulus starts a write burst near the top of the address space and steps through all 512 entries with the mask raised at every fifth address. It then reads the whole buffer back through the side port and through a read-mode sweep that itself wraps. Steps that coincide with strobes, and strobes with the reserved code, are checked by writing one marker nibble afterwards and locating it.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 4;

  typedef enum logic [1:0] {
    XK_READ   = 2'b00,
    XK_WRITE  = 2'b01,
    XK_PSEUDO = 2'b10,
    XK_RSVD   = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/sam_ptr.sv
module sam_ptr #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_o <= '0;
    else if (load_i)      ptr_o <= load_addr_i;
    else if (step_i) begin
      if (ptr_o == LAST)  ptr_o <= '0;
      else                ptr_o <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/sam_mode.sv
module sam_mode
  import sam_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] kind_i,
  output logic       load_o,
  output logic       write_mode_o
);
  xfer_kind_e kind;
  assign kind   = xfer_kind_e'(kind_i);
  assign load_o = strobe_i && (kind != XK_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     write_mode_o <= 1'b0;
    else if (load_o) write_mode_o <= (kind == XK_WRITE) || (kind == XK_PSEUDO);
  end
endmodule

// File: rtl/sam_store.sv
module sam_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/sam_port.sv
module sam_port
  import sam_pkg::*;
#(
  parameter int ADDR_W = sam_pkg::ADDR_W,
  parameter int DATA_W = sam_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_strobe_i,
  input  logic [1:0]        xfer_kind_i,
  input  logic [ADDR_W-1:0] xfer_addr_i,
  input  logic              step_i,
  input  logic              mask_i,
  input  logic [DATA_W-1:0] sdata_i,
  output logic [DATA_W-1:0] sdata_o,
  output logic              sdata_oe_o,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o
);
  logic              load;
  logic              write_mode_q;
  logic              step_ok;
  logic              wr_en;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] ptr_data;

  // strobe wins over a coincident step
  assign step_ok = step_i && !xfer_strobe_i;
  assign wr_en   = step_ok && write_mode_q && !mask_i;

  sam_mode u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strobe_i     (xfer_strobe_i),
    .kind_i       (xfer_kind_i),
    .load_o       (load),
    .write_mode_o (write_mode_q)
  );

  sam_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (xfer_addr_i),
    .step_i      (step_ok),
    .ptr_o       (ptr_q)
  );

  sam_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .waddr_i   (ptr_q),
    .wdata_i   (sdata_i),
    .raddr_a_i (ptr_q),
    .rdata_a_o (ptr_data),
    .raddr_b_i (peek_addr_i),
    .rdata_b_o (peek_data_o)
  );

  assign sdata_oe_o = !write_mode_q && !mask_i;
  assign sdata_o    = sdata_oe_o ? ptr_data : '0;
endmodule

// File: rtl/sam_port_chk.sv
module sam_port_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_strobe_i,
  input logic [1:0]        xfer_kind_i,
  input logic [ADDR_W-1:0] xfer_addr_i,
  input logic              step_i,
  input logic              mask_i,
  input logic              sdata_oe_o,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              write_mode_q
);
  // R3
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_strobe_i && xfer_kind_i != 2'b11) |=> ptr_q == $past(xfer_addr_i));
  // R2
  read_mode_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_strobe_i && xfer_kind_i == 2'b00) |=> !write_mode_q);
  // R2
  write_mode_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_strobe_i && (xfer_kind_i == 2'b01 || xfer_kind_i == 2'b10)) |=> write_mode_q);
  // R4
  rsvd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_strobe_i && xfer_kind_i == 2'b11) |=> ($stable(ptr_q) && $stable(write_mode_q)));
  // R7 R8
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !xfer_strobe_i) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
  // R10
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !xfer_strobe_i) |=> $stable(ptr_q));
  // R9
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (!write_mode_q && !mask_i));
endmodule

bind sam_port sam_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .xfer_strobe_i (xfer_strobe_i),
  .xfer_kind_i   (xfer_kind_i),
  .xfer_addr_i   (xfer_addr_i),
  .step_i        (step_i),
  .mask_i        (mask_i),
  .sdata_oe_o    (sdata_oe_o),
  .ptr_q         (ptr_q),
  .write_mode_q  (write_mode_q)
);

// File: tb/sam_port_test.sv
`timescale 1ns/1ps
module sam_port_test;
  localparam int AW = 9;
  localparam int DW = 4;
  localparam int DEPTH = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic [1:0]    kind = 2'b00;
  logic [AW-1:0] xaddr = '0;
  logic          step = 1'b0;
  logic          mask = 1'b0;
  logic [DW-1:0] sdi = '0;
  logic [DW-1:0] sdo;
  logic          oe;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_mem [DEPTH];

  always #5 clk = ~clk;

  sam_port uut (
    .clk_i(clk), .rst_ni(rst_n), .xfer_strobe_i(strobe), .xfer_kind_i(kind),
    .xfer_addr_i(xaddr), .step_i(step), .mask_i(mask), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe_o(oe), .peek_addr_i(paddr), .peek_data_o(pdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    strobe = 1'b0; step = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] k, input int a);
    strobe = 1'b1; kind = k; xaddr = AW'(a); cyc();
  endtask

  task automatic sstep(input logic m, input int d);
    step = 1'b1; mask = m; sdi = DW'(d); cyc(); mask = 1'b0;
  endtask

  task automatic peek(input string tag, input int a, input int exp);
    paddr = AW'(a); #1; chk(tag, int'(pdata), exp);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", int'(oe), 1);
    chk("R1 data", int'(sdo), 0);
    peek("R1 peek", 311, 0);

    // R2 R3 R5 R6 R7 R8: full write burst from 500 with wrap, mask every 5th
    xfer(2'b01, 500);
    chk("R2 write mode oe", int'(oe), 0);
    chk("R9 data zero when off", int'(sdo), 0);
    for (int i = 0; i < DEPTH; i++) begin
      int a = (500 + i) % DEPTH;
      logic m = (a % 5 == 0);
      int d = (a * 7 + 3) % 16;
      if (!m) exp_mem[a] = DW'(d);
      sstep(m, d);
    end
    // R5 R6 R11 exhaustive side readback
    for (int a = 0; a < DEPTH; a++)
      peek((a % 5 == 0) ? "R6 masked" : "R5 written", a, int'(exp_mem[a]));

    // R2 R3 R9 R7 R8: read sweep from 505, wraps
    xfer(2'b00, 505);
    for (int i = 0; i < DEPTH; i++) begin
      int a = (505 + i) % DEPTH;
      chk("R9 oe", int'(oe), 1);
      chk("R9 read data", int'(sdo), int'(exp_mem[a]));
      sstep(1'b0, 0);
    end
    chk("R8 wrapped back", int'(sdo), int'(exp_mem[505]));

    // R9 mask disables output; R7 masked step advances in read mode
    mask = 1'b1; #1;
    chk("R9 mask oe", int'(oe), 0);
    chk("R9 mask data", int'(sdo), 0);
    mask = 1'b0;
    sstep(1'b1, 0);
    chk("R7 masked read step", int'(sdo), int'(exp_mem[506]));

    // R2 pseudo selects write mode; R3 address load
    xfer(2'b10, 20);
    chk("R2 pseudo oe", int'(oe), 0);
    sstep(1'b0, 5); exp_mem[20] = 4'd5;
    peek("R3 pseudo write", 20, 5);
    peek("R7 next untouched", 21, int'(exp_mem[21]));

    // R4 reserved code ignored: pointer 21, write mode kept
    xfer(2'b11, 300);
    chk("R4 mode kept", int'(oe), 0);
    sstep(1'b0, 6); exp_mem[21] = 4'd6;
    peek("R4 ptr kept", 21, 6);
    peek("R4 no load", 300, int'(exp_mem[300]));

    // R10 step with strobe ignored; pointer now 22
    strobe = 1'b1; kind = 2'b01; xaddr = 9'd10; step = 1'b1; sdi = 4'hF; cyc();
    peek("R10 no write", 22, int'(exp_mem[22]));
    sstep(1'b0, 9); exp_mem[10] = 4'd9;
    peek("R10 no advance", 10, 9);
    peek("R10 next clean", 11, int'(exp_mem[11]));

    // R8 write wrap at 511 then 0
    xfer(2'b01, 511);
    sstep(1'b0, 12); sstep(1'b0, 13);
    exp_mem[511] = 4'd12; exp_mem[0] = 4'd13;
    peek("R8 last", 511, 12);
    peek("R8 first", 0, 13);

    // R2 back to read mode, strobe alone sets output
    xfer(2'b00, 0);
    chk("R2 read oe", int'(oe), 1);
    chk("R9 read first", int'(sdo), 13);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule